// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates among the twenty interrupt sources of an 8051-class microcontroller core and hands the core a vector-call request. It takes the raw request flags from the peripherals, merges the grouped flags of each source into one request, and masks that request with a master enable and a per-source enable. It then resolves priority. A two-bit level per source decides first. A fixed natural order, which does not follow vector address, settles ties within a level.

Polling happens on machine-cycle strobes. A call can be granted only on the closing machine cycle of an instruction. No call is granted while the core is executing a return-from-interrupt or writing an enable or priority register. A call is also refused unless the winning level is strictly above every level now in service. A granted call appears one clock later as a single-cycle pulse carrying the 16-bit vector address. In the same cycle, a clear strobe goes to the timer 0/1 flags and to the external interrupt 0/1 flags when those are in edge mode. The block keeps one in-service bit per level. It sets the bit on a grant and drops the highest one on a return-from-interrupt.

Top module: `irq_vector_ctl`

## Requirements
- R1: The `flags` bus maps to sources, natural index first: bit0 ext0 (0), bit1 timer0 (1), bit2 ext1 (2), bit3 timer1 (3), bits5:4 serial0 (4), bits7:6 timer2 (5), bit8 ADC (6), bit9 I2C (7), bits11:10 serial1 (8), bits14:12 SPI (9), bits18:15 ext2..ext5 (10..13), bit19 PWM period (14), bit20 PWM brake (15), bit21 timer3 (16), bits26:22 capture/QEI (17), bit27 NVM (18), bit28 watchdog (19). A source requests when any bit of its group is 1.
- R2: A source is considered only when `glob_en` is 1 and its bit in `src_en` is 1.
- R3: The level of source s is {`prio_hi[s]`,`prio_lo[s]`}, 3 highest. The highest pending level wins.
- R4: Within the winning level, the lowest natural index wins. For example, serial1 (index 8) beats ext2 (index 10).
- R5: The vector addresses by natural index 0..19 are 0003h, 000Bh, 0013h, 001Bh, 0023h, 002Bh, 0033h, 003Bh, 007Bh, 0083h, 0043h, 004Bh, 0053h, 005Bh, 0073h, 006Bh, 008Bh, 0093h, 009Bh, 0063h.
- R6: A grant is possible only in a clock where `mc_tick` and `last_cyc` are both 1.
- R7: No grant occurs in a polling clock where `blk_wr` or `reti_now` is 1.
- R8: A grant needs a winning level strictly greater than the highest in-service level. A grant marks its level in service. A polling clock with `reti_now` removes the highest in-service level.
- R9: `vec_call` is a one-clock pulse in the clock after the granting poll. `vec_addr` changes only together with that pulse and otherwise holds.
- R10: With the pulse, `hw_clr` carries one bit for a granted hardware-cleared source: bit0 ext0 when `ext_edge[0]`, bit1 timer0, bit2 ext1 when `ext_edge[1]`, bit3 timer1. Otherwise `hw_clr` is 0.
- R11: During reset, `vec_call`, `vec_addr` and `hw_clr` are all 0, and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mc_tick | input | 1 | Machine-cycle strobe; polling happens only here |
| last_cyc | input | 1 | Current machine cycle closes the instruction |
| blk_wr | input | 1 | Current instruction writes an enable or priority register |
| reti_now | input | 1 | Current instruction is a return-from-interrupt |
| flags | input | 29 | Raw peripheral request flags, positions per R1 |
| glob_en | input | 1 | Master interrupt enable |
| src_en | input | 20 | Per-source enables, natural index order |
| prio_lo | input | 20 | Low bit of each source level |
| prio_hi | input | 20 | High bit of each source level |
| ext_edge | input | 2 | Edge mode for external interrupts 0 and 1 |
| vec_call | output | 1 | Vector-call pulse |
| vec_addr | output | 16 | Vector address of the latest grant |
| hw_clr | output | 4 | Flag clear strobe for hardware-cleared sources |

## Verification
A corrupted in-service mask is not visible until the next poll that compares against it. It then shows as a missing grant or an extra nested grant, either in the clock after that poll or after a later return-from-interrupt pops the wrong level. The bench therefore runs long random sequences of nesting and returns against its own model of the mask. A wrong merge or a wrong priority pick shows at once as a wrong `vec_addr` in the pulse clock. Directed cases cover ties across non-ascending addresses and level-beats-order.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 20;
  localparam int LVL_W  = 2;
  localparam int NLVL   = 1 << LVL_W;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int VEC_W  = 16;
  localparam int HWC_W  = 4;

  // number of raw flags merged into source s
  function automatic int grp_width(input int s);
    case (s)
      4, 5, 8: return 2;
      9:       return 3;
      17:      return 5;
      default: return 1;
    endcase
  endfunction

  // lowest raw-flag position of source s
  function automatic int grp_base(input int s);
    int acc;
    acc = 0;
    for (int k = 0; k < s; k++) acc += grp_width(k);
    return acc;
  endfunction

  localparam int FLAG_W = grp_base(NSRC);

  // vector address by natural index
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] s);
    int i;
    i = int'(s);
    if (i < 8)                return VEC_W'(3 + 8 * i);
    else if (i >= 10 && i <= 13) return VEC_W'(67 + 8 * (i - 10));
    else begin
      case (i)
        8:       return VEC_W'(123);
        9:       return VEC_W'(131);
        14:      return VEC_W'(115);
        15:      return VEC_W'(107);
        16:      return VEC_W'(139);
        17:      return VEC_W'(147);
        18:      return VEC_W'(155);
        default: return VEC_W'(99);
      endcase
    end
  endfunction
endpackage

// File: rtl/irq_merge.sv
module irq_merge
  import irq_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int FW = FLAG_W
) (
  input  logic [FW-1:0] flags,
  input  logic          glob_en,
  input  logic [N-1:0]  src_en,
  output logic [N-1:0]  pend
);
  logic [N-1:0] raw_req;

  for (genvar s = 0; s < N; s++) begin : g_src
    localparam int LO = grp_base(s);
    localparam int W  = grp_width(s);
    assign raw_req[s] = |flags[LO +: W];
  end

  assign pend = raw_req & src_en & {N{glob_en}};
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_pkg::*;
#(
  parameter int N  = NSRC,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     prio_lo,
  input  logic [N-1:0]     prio_hi,
  output logic             any_pend,
  output logic [IW-1:0]    best_idx,
  output logic [LVL_W-1:0] best_lvl
);
  logic [NLVL-1:0][N-1:0] lvl_mask;
  logic [N-1:0]           win_mask;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar s = 0; s < N; s++) begin : g_src
      assign lvl_mask[l][s] = pend[s] && ({prio_hi[s], prio_lo[s]} == LVL_W'(l));
    end
  end

  always_comb begin
    best_lvl = '0;
    any_pend = 1'b0;
    for (int l = 0; l < NLVL; l++) begin
      if (|lvl_mask[l]) begin
        best_lvl = LVL_W'(l);
        any_pend = 1'b1;
      end
    end
    win_mask = lvl_mask[best_lvl];
    best_idx = '0;
    for (int s = N - 1; s >= 0; s--) begin
      if (win_mask[s]) best_idx = IW'(s);
    end
  end
endmodule

// File: rtl/irq_svc.sv
module irq_svc
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [LVL_W-1:0] set_lvl,
  input  logic             pop_en,
  output logic             act_valid,
  output logic [LVL_W-1:0] act_lvl
);
  logic [NLVL-1:0] svc_q;
  logic [NLVL-1:0] svc_d;
  logic            svc_upd;

  always_comb begin
    act_valid = |svc_q;
    act_lvl   = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (svc_q[l]) act_lvl = LVL_W'(l);
    end
  end

  always_comb begin
    svc_d   = svc_q;
    svc_upd = set_en | (pop_en & act_valid);
    if (set_en)                    svc_d[set_lvl] = 1'b1;
    else if (pop_en && act_valid)  svc_d[act_lvl] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       svc_q <= '0;
    else if (svc_upd) svc_q <= svc_d;
  end

  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && act_valid) |-> (set_lvl > act_lvl)); // R8
  AST_NO_SET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && pop_en)); // R7
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              last_cyc,
  input  logic              blk_wr,
  input  logic              reti_now,
  input  logic [FLAG_W-1:0] flags,
  input  logic              glob_en,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NSRC-1:0]   prio_lo,
  input  logic [NSRC-1:0]   prio_hi,
  input  logic [1:0]        ext_edge,
  output logic              vec_call,
  output logic [VEC_W-1:0]  vec_addr,
  output logic [HWC_W-1:0]  hw_clr
);
  logic [NSRC-1:0]  pend;
  logic             any_pend;
  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] best_lvl;
  logic             act_valid;
  logic [LVL_W-1:0] act_lvl;
  logic             poll;
  logic             take;
  logic             pop;

  logic             call_q, call_d;
  logic [VEC_W-1:0] addr_q, addr_d;
  logic [HWC_W-1:0] clr_q, clr_d;

  irq_merge #(.N(NSRC), .FW(FLAG_W)) u_merge (
    .flags  (flags),
    .glob_en(glob_en),
    .src_en (src_en),
    .pend   (pend)
  );

  irq_resolve #(.N(NSRC)) u_resolve (
    .pend    (pend),
    .prio_lo (prio_lo),
    .prio_hi (prio_hi),
    .any_pend(any_pend),
    .best_idx(best_idx),
    .best_lvl(best_lvl)
  );

  irq_svc u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (take),
    .set_lvl  (best_lvl),
    .pop_en   (pop),
    .act_valid(act_valid),
    .act_lvl  (act_lvl)
  );

  always_comb begin
    poll = mc_tick & last_cyc;
    take = poll & ~blk_wr & ~reti_now & any_pend &
           (~act_valid | (best_lvl > act_lvl));
    pop  = poll & reti_now;
  end

  always_comb begin
    call_d = take;
    addr_d = take ? vec_of(best_idx) : addr_q;
    clr_d  = '0;
    if (take) begin
      case (best_idx)
        IDX_W'(0): clr_d[0] = ext_edge[0];
        IDX_W'(1): clr_d[1] = 1'b1;
        IDX_W'(2): clr_d[2] = ext_edge[1];
        IDX_W'(3): clr_d[3] = 1'b1;
        default:   clr_d    = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_q <= 1'b0;
      addr_q <= '0;
      clr_q  <= '0;
    end else begin
      call_q <= call_d;
      clr_q  <= clr_d;
      if (take) addr_q <= addr_d;
    end
  end

  assign vec_call = call_q;
  assign vec_addr = addr_q;
  assign hw_clr   = clr_q;

  AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> pend[best_idx]); // R3
  AST_CALL_ON_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_call |-> $past(mc_tick && last_cyc && !blk_wr && !reti_now)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_call |-> $stable(vec_addr)); // R9
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hw_clr)); // R10
  AST_CLR_WITH_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_clr) |-> vec_call); // R10
endmodule

// File: tb/tb_irq_vector_ctl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctl;
  localparam int CLK_P = 10;
  localparam int NS    = 20;
  localparam int FW    = 29;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mc_tick, last_cyc, blk_wr, reti_now, glob_en;
  logic [FW-1:0] flags;
  logic [NS-1:0] src_en, prio_lo, prio_hi;
  logic [1:0]    ext_edge;
  logic          vec_call;
  logic [15:0]   vec_addr;
  logic [3:0]    hw_clr;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  logic [3:0]  m_svc;
  logic [15:0] m_addr;

  always #(CLK_P/2) clk = ~clk;

  irq_vector_ctl dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .last_cyc(last_cyc),
    .blk_wr(blk_wr), .reti_now(reti_now), .flags(flags), .glob_en(glob_en),
    .src_en(src_en), .prio_lo(prio_lo), .prio_hi(prio_hi), .ext_edge(ext_edge),
    .vec_call(vec_call), .vec_addr(vec_addr), .hw_clr(hw_clr)
  );

  function automatic logic src_req(input logic [FW-1:0] f, input int s);
    case (s)
      0: return f[0];   1: return f[1];   2: return f[2];   3: return f[3];
      4: return |f[5:4];   5: return |f[7:6];
      6: return f[8];   7: return f[9];
      8: return |f[11:10]; 9: return |f[14:12];
      10: return f[15]; 11: return f[16]; 12: return f[17]; 13: return f[18];
      14: return f[19]; 15: return f[20]; 16: return f[21];
      17: return |f[26:22];
      18: return f[27];
      default: return f[28];
    endcase
  endfunction

  function automatic logic [15:0] exp_vec(input int s);
    case (s)
      0: return 16'h0003; 1: return 16'h000B; 2: return 16'h0013; 3: return 16'h001B;
      4: return 16'h0023; 5: return 16'h002B; 6: return 16'h0033; 7: return 16'h003B;
      8: return 16'h007B; 9: return 16'h0083; 10: return 16'h0043; 11: return 16'h004B;
      12: return 16'h0053; 13: return 16'h005B; 14: return 16'h0073; 15: return 16'h006B;
      16: return 16'h008B; 17: return 16'h0093; 18: return 16'h009B;
      default: return 16'h0063;
    endcase
  endfunction

  function automatic int top_lvl(input logic [3:0] m);
    int r;
    r = -1;
    for (int l = 0; l < 4; l++) if (m[l]) r = l;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply current inputs for one clock and check the registered result
  task automatic step(input string tag);
    int best, blvl, act, lv;
    bit take;
    logic [3:0] e_clr;
    best = -1; blvl = -1;
    for (int s = 0; s < NS; s++) begin
      if (src_req(flags, s) && src_en[s] && glob_en) begin
        lv = {prio_hi[s], prio_lo[s]};
        if (lv > blvl) begin blvl = lv; best = s; end
      end
    end
    act  = top_lvl(m_svc);
    take = mc_tick && last_cyc && !blk_wr && !reti_now && (best >= 0) && (blvl > act);
    e_clr = 4'b0;
    if (take) begin
      if (best == 0 && ext_edge[0]) e_clr = 4'b0001;
      if (best == 1)                e_clr = 4'b0010;
      if (best == 2 && ext_edge[1]) e_clr = 4'b0100;
      if (best == 3)                e_clr = 4'b1000;
      m_svc[blvl] = 1'b1;
      m_addr = exp_vec(best);
    end else if (mc_tick && last_cyc && reti_now && act >= 0) begin
      m_svc[act] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(vec_call == take, tag, 32'(vec_call), 32'(take));
    if (take) check(vec_addr == m_addr, "R5 vector", 32'(vec_addr), 32'(m_addr));
    else      check(vec_addr == m_addr, "R9 address held", 32'(vec_addr), 32'(m_addr));
    check(hw_clr == e_clr, "R10 clear strobe", 32'(hw_clr), 32'(e_clr));
  endtask

  task automatic idle_in();
    mc_tick = 1'b0; last_cyc = 1'b0; blk_wr = 1'b0; reti_now = 1'b0;
    flags = '0; glob_en = 1'b1; src_en = '1; prio_lo = '0; prio_hi = '0;
    ext_edge = 2'b00;
  endtask

  task automatic poll_with(input logic [FW-1:0] f, input string tag);
    flags = f; mc_tick = 1'b1; last_cyc = 1'b1;
    step(tag);
    idle_in();
  endtask

  task automatic ret_all();
    for (int k = 0; k < 4; k++) begin
      idle_in(); mc_tick = 1'b1; last_cyc = 1'b1; reti_now = 1'b1;
      step("R8 return pop");
    end
    idle_in();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    m_svc = '0; m_addr = '0;
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(vec_call == 1'b0, "R11 reset call", 32'(vec_call), 0);
    check(vec_addr == 16'h0, "R11 reset addr", 32'(vec_addr), 0);
    check(hw_clr == 4'h0, "R11 reset clr", 32'(hw_clr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 grouped flags: each member of serial1 and capture groups
    poll_with(29'(1) << 11, "R1 serial1 tx flag"); ret_all();
    poll_with(29'(1) << 25, "R1 capture group member"); ret_all();
    poll_with(29'(1) << 13, "R1 spi group member"); ret_all();
    // R4 tie: serial1 (idx 8, 007Bh) beats ext2 (idx 10, 0043h)
    poll_with((29'(1) << 10) | (29'(1) << 15), "R4 natural order tie"); ret_all();
    // R3 level beats order
    prio_lo[10] = 1'b1;
    poll_with((29'(1) << 10) | (29'(1) << 15), "R3 higher level wins"); ret_all();
    // R2 masking
    glob_en = 1'b0; poll_with(29'(1) << 8, "R2 global disable");
    src_en[6] = 1'b0; poll_with(29'(1) << 8, "R2 source disable");
    // R6 polling window
    last_cyc = 1'b0; mc_tick = 1'b1; flags = 29'(1) << 9; step("R6 not last cycle"); idle_in();
    last_cyc = 1'b1; flags = 29'(1) << 9; step("R6 no tick"); idle_in();
    // R7 blocking
    blk_wr = 1'b1; poll_with(29'(1) << 9, "R7 register write blocks");
    reti_now = 1'b1; poll_with(29'(1) << 9, "R7 reti blocks");
    // R8 nesting
    prio_lo[6] = 1'b1; poll_with(29'(1) << 8, "R8 level1 granted");
    prio_lo[7] = 1'b1; poll_with(29'(1) << 9, "R8 same level refused");
    prio_hi[19] = 1'b1; poll_with(29'(1) << 28, "R8 level2 nests");
    mc_tick = 1'b1; last_cyc = 1'b1; reti_now = 1'b1; step("R8 pop level2"); idle_in();
    prio_lo[7] = 1'b1; poll_with(29'(1) << 9, "R8 still blocked by level1");
    ret_all();
    // R10 hardware clears
    ext_edge = 2'b01; poll_with(29'(1) << 0, "R10 ext0 edge"); ret_all();
    poll_with(29'(1) << 0, "R10 ext0 level"); ret_all();
    poll_with(29'(1) << 3, "R10 timer1"); ret_all();
    ext_edge = 2'b10; poll_with(29'(1) << 2, "R10 ext1 edge"); ret_all();
    // R9 pulse only one clock
    poll_with(29'(1) << 21, "R9 grant"); step("R9 pulse ends"); ret_all();

    // constrained random
    for (int it = 0; it < 4000; it++) begin
      for (int b = 0; b < FW; b++) flags[b] = ($urandom_range(0, 7) == 0);
      for (int s = 0; s < NS; s++) begin
        src_en[s]  = ($urandom_range(0, 3) != 0);
        prio_lo[s] = 1'($urandom_range(0, 1));
        prio_hi[s] = 1'($urandom_range(0, 1));
      end
      glob_en  = ($urandom_range(0, 9) != 0);
      mc_tick  = ($urandom_range(0, 9) < 7);
      last_cyc = ($urandom_range(0, 9) < 6);
      blk_wr   = ($urandom_range(0, 9) == 0);
      reti_now = ($urandom_range(0, 7) == 0);
      ext_edge = 2'($urandom_range(0, 3));
      step("R6 random grant");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule